// File: doc/BRIEF.md
# Host I/O Port Write Snoop Queue

This block sits on the management-controller side of a host I/O bus and watches the host's I/O write cycles. It is usually used to capture the progress codes that platform firmware emits during power-on self test. Firmware on the management controller programs two 16-bit I/O port numbers. Each host write that hits one of them is queued as the data byte plus a one-bit tag. Firmware then drains the queue through a small byte-wide register window. A level interrupt reports that entries are waiting, or that the host reset line has changed state.

The host side is a decoded write strobe with a 16-bit port number and a data byte. Cycle-level decoding of the physical bus is done upstream. In normal mode the tag names the port that matched. In grouped mode the block captures a four-port window that starts at the first programmed port, ignores the second port, and sets the tag only on the byte written to the last port of the window. Firmware uses that tag to tell where each 32-bit value ends.

Top module: `io_post_snoop`

## Requirements
- R1: The first port number is held in registers at offsets 0x10 (bits 7:0) and 0x12 (bits 15:8). The second port number is held at offsets 0x02 (bits 7:0) and 0x04 (bits 15:8). All four registers read back what was written, and they reset to 0.
- R2: The control register is at offset 0x06. Bit 7 enables the first port, bit 6 enables the second port, bit 4 enables the reset interrupt, bit 3 enables the data interrupt and bit 2 selects grouped mode. The other bits read 0. In normal mode, a host write to an enabled port queues its data with tag 0 for the first port and tag 1 for the second port. Entries leave the queue in arrival order.
- R3: A host write to a port that is not enabled, or that is not programmed, leaves the queue unchanged.
- R4: Status is at offset 0x08. Bit 7 means an entry is waiting, bit 5 is the overflow flag and bit 0 is the head entry's tag (0 when the queue is empty). Reading offset 0x0A returns the head byte and removes it. Reading 0x0A when the queue is empty returns 0x00 and removes nothing.
- R5: The queue holds 16 entries. A matching write that arrives while 16 entries are held is dropped and sets the overflow flag. The flag stays set until status is read; that read returns 1 and clears the flag.
- R6: When a host write and a data-register read fall in the same cycle, one entry is added and one is removed, so the count is unchanged.
- R7: In grouped mode (bit 2 set), writes to ports P through P+3 are captured, where P is the first port, whatever the port enable bits say. The second port is ignored. Only the byte written to P+3 carries tag 1.
- R8: The interrupt output is high exactly when (data interrupt enabled and an entry is waiting) or (reset interrupt enabled and the reset-change flag is set).
- R9: Each edge of the host reset input, after a two-flop synchronizer, sets the reset-change flag. This flag is bit 6 of offset 0x0C and is cleared by writing 1 to that bit.
- R10: When both ports are enabled and hold the same number, a write to that number is queued once, with tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_stb | input | 1 | One-cycle strobe for a decoded host I/O write |
| host_port | input | 16 | I/O port number of the host write |
| host_data | input | 8 | Data byte of the host write |
| host_rst_in | input | 1 | Host reset level, asynchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reads with side effects act at the clock edge |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the cycle that reg_rd is high |
| irq | output | 1 | Level interrupt |

## Verification
A matching host write is registered into the queue at the edge that samples its strobe. Status, the read data and the interrupt reflect the new entry right after that edge, so the bench samples them one nanosecond after it. Register reads are combinational in the cycle of the strobe, and their side effects (removing an entry, clearing the overflow flag) take effect at the same edge. A host reset edge reaches the flag on the third clock edge after the input moves. The bench therefore reads the flag once between the second and third edges, where it must still be clear, and once after the third edge, where it must be set. A scoreboard queue predicts each captured entry at the moment the driver issues the write, and every drain compares the entries in order against that queue.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  localparam int PORT_W  = 16;
  localparam int DATA_W  = 8;
  localparam int REG_AW  = 5;
  localparam int DW_SPAN = 4;

  localparam logic [REG_AW-1:0] OFS_PB_LO = 5'h02;
  localparam logic [REG_AW-1:0] OFS_PB_HI = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h06;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_DATA  = 5'h0A;
  localparam logic [REG_AW-1:0] OFS_MISC  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_PA_LO = 5'h10;
  localparam logic [REG_AW-1:0] OFS_PA_HI = 5'h12;

  localparam int B_EN_A   = 7;
  localparam int B_EN_B   = 6;
  localparam int B_RST_IE = 4;
  localparam int B_RDY_IE = 3;
  localparam int B_GROUP  = 2;
  localparam int B_VALID  = 7;
  localparam int B_OVF    = 5;
  localparam int B_TAG    = 0;
  localparam int B_RSTCHG = 6;

  typedef struct packed {
    logic              tag;
    logic [DATA_W-1:0] data;
  } snoop_entry_t;
endpackage

// File: rtl/snoop_match.sv
module snoop_match
  import snoop_pkg::*;
(
  input  logic              stb,
  input  logic [PORT_W-1:0] addr,
  input  logic [PORT_W-1:0] port_a,
  input  logic [PORT_W-1:0] port_b,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              group_mode,
  output logic              hit,
  output logic              tag
);
  localparam int SPAN_W = $clog2(DW_SPAN);

  logic [PORT_W-1:0] offs;
  logic              in_win;
  logic              at_last;

  assign offs    = addr - port_a;
  assign in_win  = (offs[PORT_W-1:SPAN_W] == '0);
  assign at_last = in_win && (offs[SPAN_W-1:0] == SPAN_W'(DW_SPAN - 1));

  always_comb begin
    hit = 1'b0;
    tag = 1'b0;
    if (group_mode) begin
      hit = stb && in_win;
      tag = at_last;
    end else if (en_a && (addr == port_a)) begin
      hit = stb;
      tag = 1'b0;
    end else if (en_b && (addr == port_b)) begin
      hit = stb;
      tag = 1'b1;
    end
  end
endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0]    count, count_n;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (do_push) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    if (do_push && !do_pop)      count_n = count + 1'b1;
    else if (do_pop && !do_push) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_full_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
  p_count_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> (count == $past(count)));
endmodule

// File: rtl/snoop_edge_sync.sv
module snoop_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic changed
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign changed = sync_q ^ prev_q;
endmodule

// File: rtl/io_post_snoop.sv
module io_post_snoop
  import snoop_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_stb,
  input  logic [PORT_W-1:0] host_port,
  input  logic [DATA_W-1:0] host_data,
  input  logic              host_rst_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int ENTRY_W = $bits(snoop_entry_t);

  logic [PORT_W-1:0] port_a_q, port_a_n, port_b_q, port_b_n;
  logic en_a_q, en_b_q, rst_ie_q, rdy_ie_q, group_q;
  logic en_a_n, en_b_n, rst_ie_n, rdy_ie_n, group_n;
  logic ovf_q, ovf_n, rstchg_q, rstchg_n;

  logic         snoop_hit, snoop_tag;
  snoop_entry_t push_entry, head_entry;
  logic         fifo_empty, fifo_full, pop_req;
  logic         stat_rd, misc_clr, rst_edge;

  snoop_match u_match (
    .stb        (host_wr_stb),
    .addr       (host_port),
    .port_a     (port_a_q),
    .port_b     (port_b_q),
    .en_a       (en_a_q),
    .en_b       (en_b_q),
    .group_mode (group_q),
    .hit        (snoop_hit),
    .tag        (snoop_tag)
  );

  assign push_entry = '{tag: snoop_tag, data: host_data};
  assign pop_req    = reg_rd && (reg_addr == OFS_DATA);
  assign stat_rd    = reg_rd && (reg_addr == OFS_STAT);
  assign misc_clr   = reg_wr && (reg_addr == OFS_MISC) && reg_wdata[B_RSTCHG];

  snoop_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (snoop_hit),
    .pop   (pop_req),
    .din   (push_entry),
    .dout  (head_entry),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  snoop_edge_sync u_rst_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (host_rst_in),
    .changed  (rst_edge)
  );

  always_comb begin
    port_a_n = port_a_q;
    port_b_n = port_b_q;
    en_a_n   = en_a_q;
    en_b_n   = en_b_q;
    rst_ie_n = rst_ie_q;
    rdy_ie_n = rdy_ie_q;
    group_n  = group_q;
    if (reg_wr) begin
      unique case (reg_addr)
        OFS_PA_LO: port_a_n[7:0]  = reg_wdata;
        OFS_PA_HI: port_a_n[15:8] = reg_wdata;
        OFS_PB_LO: port_b_n[7:0]  = reg_wdata;
        OFS_PB_HI: port_b_n[15:8] = reg_wdata;
        OFS_CTRL: begin
          en_a_n   = reg_wdata[B_EN_A];
          en_b_n   = reg_wdata[B_EN_B];
          rst_ie_n = reg_wdata[B_RST_IE];
          rdy_ie_n = reg_wdata[B_RDY_IE];
          group_n  = reg_wdata[B_GROUP];
        end
        default: ;
      endcase
    end
    ovf_n    = (snoop_hit && fifo_full) ? 1'b1 : (stat_rd ? 1'b0 : ovf_q);
    rstchg_n = rst_edge ? 1'b1 : (misc_clr ? 1'b0 : rstchg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_a_q <= '0;
      port_b_q <= '0;
      en_a_q   <= 1'b0;
      en_b_q   <= 1'b0;
      rst_ie_q <= 1'b0;
      rdy_ie_q <= 1'b0;
      group_q  <= 1'b0;
      ovf_q    <= 1'b0;
      rstchg_q <= 1'b0;
    end else begin
      port_a_q <= port_a_n;
      port_b_q <= port_b_n;
      en_a_q   <= en_a_n;
      en_b_q   <= en_b_n;
      rst_ie_q <= rst_ie_n;
      rdy_ie_q <= rdy_ie_n;
      group_q  <= group_n;
      ovf_q    <= ovf_n;
      rstchg_q <= rstchg_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_PA_LO: reg_rdata = port_a_q[7:0];
        OFS_PA_HI: reg_rdata = port_a_q[15:8];
        OFS_PB_LO: reg_rdata = port_b_q[7:0];
        OFS_PB_HI: reg_rdata = port_b_q[15:8];
        OFS_CTRL: begin
          reg_rdata[B_EN_A]   = en_a_q;
          reg_rdata[B_EN_B]   = en_b_q;
          reg_rdata[B_RST_IE] = rst_ie_q;
          reg_rdata[B_RDY_IE] = rdy_ie_q;
          reg_rdata[B_GROUP]  = group_q;
        end
        OFS_STAT: begin
          reg_rdata[B_VALID] = !fifo_empty;
          reg_rdata[B_OVF]   = ovf_q;
          reg_rdata[B_TAG]   = !fifo_empty && head_entry.tag;
        end
        OFS_DATA: reg_rdata = fifo_empty ? '0 : head_entry.data;
        OFS_MISC: reg_rdata[B_RSTCHG] = rstchg_q;
        default: ;
      endcase
    end
  end

  assign irq = (rdy_ie_q && !fifo_empty) || (rst_ie_q && rstchg_q);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !stat_rd) |=> ovf_q);
  p_nomatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !snoop_hit) |=> fifo_empty);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !rstchg_q) |-> !irq);
  p_rstchg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rstchg_q && !misc_clr) |=> rstchg_q);
  p_group_skip_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (group_q && snoop_hit) |-> ((host_port - port_a_q) < PORT_W'(DW_SPAN)));
endmodule

// File: tb/test_io_post_snoop.sv
module test_io_post_snoop;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_stb = 1'b0;
  logic [15:0] host_port = '0;
  logic [7:0]  host_data = '0;
  logic        host_rst_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [8:0] exp_q[$];
  logic [15:0] m_pa = '0, m_pb = '0;
  logic m_ena = 0, m_enb = 0, m_grp = 0, m_ovf = 0;

  always #2 clk = ~clk;

  io_post_snoop i_io_post_snoop (
    .clk(clk), .rst_n(rst_n), .host_wr_stb(host_wr_stb), .host_port(host_port),
    .host_data(host_data), .host_rst_in(host_rst_in), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model_hit(input logic [15:0] p);
    logic [15:0] d;
    d = p - m_pa;
    if (m_grp) return {d < 16'd4, d == 16'd3};
    if (m_ena && p == m_pa) return 2'b10;
    if (m_enb && p == m_pb) return 2'b11;
    return 2'b00;
  endfunction

  task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  // driver: predicts the entry and pushes it onto the scoreboard
  task automatic predict(input logic [15:0] p, input logic [7:0] d, input int queue_out);
    logic [1:0] h;
    h = model_hit(p);
    if (h[1]) begin
      if (exp_q.size() - queue_out >= 16) m_ovf = 1;
      else exp_q.push_back({h[0], d});
    end
  endtask

  task automatic host_write(input logic [15:0] p, input logic [7:0] d);
    predict(p, d, 0);
    @(negedge clk);
    host_wr_stb = 1; host_port = p; host_data = d;
    @(posedge clk); #1;
    host_wr_stb = 0;
  endtask

  // monitor: drains the design and compares against the scoreboard
  task automatic drain(input string req);
    logic [7:0] st, dv;
    logic [8:0] e;
    for (int i = 0; i < 40; i++) begin
      reg_read(5'h08, st);
      if (!st[7]) break;
      reg_read(5'h0A, dv);
      if (exp_q.size() == 0) begin
        chk({req, " unexpected entry"}, {23'd0, st[0], dv}, 32'h1FF);
      end else begin
        e = exp_q.pop_front();
        chk({req, " entry"}, {23'd0, st[0], dv}, {23'd0, e});
      end
    end
    chk({req, " scoreboard empty"}, exp_q.size(), 0);
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    reg_write(5'h06, v);
    m_ena = v[7]; m_enb = v[6]; m_grp = v[2];
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R8 irq after reset", irq, 0);
    reg_read(5'h08, v); chk("R4 status after reset", v, 8'h00);
    reg_read(5'h06, v); chk("R2 ctrl after reset", v, 8'h00);
    reg_read(5'h10, v); chk("R1 port a reset", v, 8'h00);

    // R1 programming
    reg_write(5'h10, 8'h80); reg_write(5'h12, 8'h00);
    reg_write(5'h02, 8'h84); reg_write(5'h04, 8'h12);
    m_pa = 16'h0080; m_pb = 16'h1284;
    reg_read(5'h10, v); chk("R1 port a lo", v, 8'h80);
    reg_read(5'h04, v); chk("R1 port b hi", v, 8'h12);
    reg_read(5'h02, v); chk("R1 port b lo", v, 8'h84);

    // R2 normal capture, R8 interrupt
    set_ctrl(8'hC8);
    reg_read(5'h06, v); chk("R2 ctrl readback", v, 8'hC8);
    host_write(16'h0080, 8'h11);
    chk("R8 irq with data", irq, 1);
    host_write(16'h1284, 8'h22);
    host_write(16'h0084, 8'h33);
    host_write(16'h0080, 8'h44);
    drain("R2 two ports");
    #1 chk("R8 irq after drain", irq, 0);
    reg_read(5'h0A, v); chk("R4 empty data read", v, 8'h00);
    reg_read(5'h08, v); chk("R4 empty status", v, 8'h00);

    // R3 disabled port ignored
    set_ctrl(8'h88);
    host_write(16'h1284, 8'h55);
    host_write(16'h0081, 8'h56);
    reg_read(5'h08, v); chk("R3 no capture", v[7], 0);

    // R10 both ports equal
    reg_write(5'h02, 8'h80); reg_write(5'h04, 8'h00); m_pb = 16'h0080;
    set_ctrl(8'hC8);
    host_write(16'h0080, 8'h5A);
    drain("R10 equal ports");

    // R5 overflow
    for (int i = 0; i < 18; i++) host_write(16'h0080, 8'(8'hA0 + i));
    reg_read(5'h08, v); chk("R5 overflow set", v[5], m_ovf);
    chk("R5 overflow set value", v[5], 1);
    reg_read(5'h08, v); chk("R5 overflow cleared by read", v[5], 0);
    m_ovf = 0;
    drain("R5 sixteen kept");

    // R6 simultaneous push and pop
    for (int i = 0; i < 3; i++) host_write(16'h0080, 8'(8'hC0 + i));
    begin
      logic [8:0] e;
      e = exp_q.pop_front();
      predict(16'h1284, 8'h00, 0); // port b now 0x0080 so rewrite model first
    end
    exp_q.delete();
    exp_q.push_back({1'b0, 8'hC1}); exp_q.push_back({1'b0, 8'hC2});
    @(negedge clk);
    host_wr_stb = 1; host_port = 16'h0080; host_data = 8'hC9;
    reg_rd = 1; reg_addr = 5'h0A;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    host_wr_stb = 0; reg_rd = 0;
    chk("R6 popped head", v, 8'hC0);
    exp_q.push_back({1'b0, 8'hC9});
    drain("R6 count kept");

    // R7 grouped mode
    set_ctrl(8'h0C);
    host_write(16'h007F, 8'hB0);
    for (int i = 0; i < 4; i++) host_write(16'(16'h0080 + i), 8'(8'hD0 + i));
    host_write(16'h0084, 8'hB1);
    host_write(16'h1284, 8'hB2);
    drain("R7 grouped");

    // R9 host reset change
    set_ctrl(8'h10);
    @(negedge clk); host_rst_in = 1;
    repeat (2) @(posedge clk);
    reg_read(5'h0C, v); chk("R9 flag not before third edge", v, 8'h00);
    reg_read(5'h0C, v); chk("R9 flag set", v, 8'h40);
    #1 chk("R8 irq on reset change", irq, 1);
    reg_write(5'h0C, 8'h40);
    reg_read(5'h0C, v); chk("R9 flag cleared", v, 8'h00);
    #1 chk("R8 irq after clear", irq, 0);
    @(negedge clk); host_rst_in = 0;
    repeat (4) @(posedge clk);
    reg_read(5'h0C, v); chk("R9 falling edge", v, 8'h40);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule